// File: doc/BRIEF.md
# Hysteretic Battery Charger with Transformer Tap Selection

This block decides when a battery bank is charged from a photovoltaic source, and through which transformer secondary it is charged. It takes two 8-bit converter codes, one for the battery voltage and one for the panel voltage, each taken through a resistive divider. A code is accepted on any cycle where `adc_valid` is high, and both codes are converted to centivolts using a full-scale parameter for each channel. Charging follows a hysteresis loop between two programmable codes. While charging, the panel voltage band picks exactly one secondary tap relay, and a free-running H-bridge drives the transformer primary.

A change of tap always opens the old relay, keeps every relay open for a set number of cycles, and only then closes the new one. The H-bridge runs at the mains frequency set by parameters. Its two legs swap on each half period, and a short all-off window separates them. Whenever no relay is closed, the bridge is held off. The battery voltage is also presented in centivolts for a display.

Top module: `pv_charge_tap_ctrl`

## Requirements
- R1: On a clock edge with `adc_valid` high, `batt_cv` becomes floor(batt_code × BATT_FS_CV / 255), which gives 1200 for code 255 with the default 12 V full scale. It holds that value until the next valid sample.
- R2: When not charging, a sample with batt_code strictly below `thr_low` sets `charging` at that edge. A code equal to `thr_low` does not start charging.
- R3: When charging, a sample with batt_code at or above `thr_high` clears `charging`. A sample between the thresholds leaves `charging` unchanged in either state.
- R4: If `thr_high` is not greater than `thr_low`, a sample clears `charging` and cannot set it.
- R5: The panel voltage is pv_cv = floor(pv_code × PV_FS_CV / 255), with a default full scale of 2400. When 1000 ≤ pv_cv < 1800, the selected tap is index (pv_cv − 1000) / 200, so there are four 200-centivolt bands. Outside that span no tap is selected.
- R6: `tap_en` bit i closes relay i. At most one bit is ever set. All bits are clear while not charging or while the panel is out of range.
- R7: When the selected tap changes between two relays, `tap_en` goes to zero one cycle after the sample edge and stays zero for exactly GAP_CYC cycles before the new bit is set. A relay never switches directly to another relay.
- R8: `gate` bits are {leg B low, leg B high, leg A low, leg A high} from bit 3 down to bit 0. The positive half drives 4'b1001 and the negative half drives 4'b0110. Each half lasts CLK_HZ/(2·AC_HZ) cycles, starting with the positive half in the cycle the relay closes.
- R9: The first DEAD_CYC (2) cycles of every half are all-off. `gate` is all zero whenever `tap_en` is zero.
- R10: During and after reset, `tap_en`, `gate`, `charging` and `batt_cv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | Both codes valid this cycle |
| batt_code | input | 8 | Battery voltage converter code |
| pv_code | input | 8 | Panel voltage converter code |
| thr_low | input | 8 | Code below which charging starts |
| thr_high | input | 8 | Code at or above which charging stops |
| tap_en | output | NUM_TAPS | One-hot secondary tap relay enables |
| gate | output | 4 | H-bridge gate drives |
| charging | output | 1 | Charging active |
| batt_cv | output | 12 | Battery voltage in centivolts |

## Verification
`charging` and `batt_cv` change at the sampling edge itself, so the bench reads them at the falling edge right after that edge. A relay change takes effect one edge later. A tap swap then adds GAP_CYC all-off cycles, so the bench counts the zero cycles one falling edge at a time, and for random samples it waits GAP_CYC+3 cycles before comparing. The gate pattern is compared on every falling edge for two full periods. The count starts at the first falling edge where a relay is seen closed, because the bridge counter begins at zero in that cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int CV_W = 12;

    typedef logic [CV_W-1:0] cv_t;

    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } half_e;

    typedef struct packed {
        logic charging;
        logic in_range;
        cv_t  batt_cv;
    } chg_state_t;

    // gate bit order: [0] leg A high, [1] leg A low, [2] leg B high, [3] leg B low
    localparam logic [3:0] GATE_POS = 4'b1001;
    localparam logic [3:0] GATE_NEG = 4'b0110;

    function automatic cv_t code_to_cv(input logic [7:0] code, input int fs_cv);
        int prod;
        prod = int'(code) * fs_cv / 255;
        return cv_t'(prod);
    endfunction

    function automatic logic [3:0] gate_pattern(input half_e ph);
        return (ph == PH_POS) ? GATE_POS : GATE_NEG;
    endfunction

    function automatic logic hyst_next(input logic cur, input logic [7:0] b,
                                       input logic [7:0] lo, input logic [7:0] hi);
        if (hi <= lo)             return 1'b0;
        else if (!cur && b < lo)  return 1'b1;
        else if (cur && b >= hi)  return 1'b0;
        else                      return cur;
    endfunction

endpackage

// File: rtl/chg_sample.sv
module chg_sample
    import chg_pkg::*;
#(
    parameter int NUM_TAPS     = 4,
    parameter int BATT_FS_CV   = 1200,
    parameter int PV_FS_CV     = 2400,
    parameter int BAND_LO_CV   = 1000,
    parameter int BAND_STEP_CV = 200,
    localparam int IDX_W       = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adc_valid,
    input  logic [7:0]       batt_code,
    input  logic [7:0]       pv_code,
    input  logic [7:0]       thr_low,
    input  logic [7:0]       thr_high,
    output chg_state_t       st_q,
    output logic [IDX_W-1:0] band_q
);

    localparam int SPAN_TOP = BAND_LO_CV + NUM_TAPS * BAND_STEP_CV;

    cv_t              pv_cv;
    logic             in_rng;
    logic [IDX_W-1:0] band_n;

    always_comb begin
        pv_cv  = code_to_cv(pv_code, PV_FS_CV);
        in_rng = (int'(pv_cv) >= BAND_LO_CV) && (int'(pv_cv) < SPAN_TOP);
        band_n = in_rng ? IDX_W'((int'(pv_cv) - BAND_LO_CV) / BAND_STEP_CV) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            band_q <= '0;
        end else if (adc_valid) begin
            st_q.charging <= hyst_next(st_q.charging, batt_code, thr_low, thr_high);
            st_q.in_range <= in_rng;
            st_q.batt_cv  <= code_to_cv(batt_code, BATT_FS_CV);
            band_q        <= band_n;
        end
    end

    a_r1_display_hold: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(st_q.batt_cv));

    a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.charging) |-> $past(adc_valid && (batt_code < thr_low)));

    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        (adc_valid && thr_high > thr_low && batt_code >= thr_low && batt_code < thr_high)
        |=> (st_q.charging == $past(st_q.charging)));

    a_r4_bad_cfg_idle: assert property (@(posedge clk) disable iff (rst)
        (adc_valid && thr_high <= thr_low) |=> !st_q.charging);

endmodule

// File: rtl/chg_tap_seq.sv
module chg_tap_seq #(
    parameter int NUM_TAPS = 4,
    parameter int GAP_CYC  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAPS-1:0] target,
    output logic [NUM_TAPS-1:0] tap_en
);

    localparam int            GW       = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(GAP_CYC);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_en  <= '0;
            gap_cnt <= '0;
        end else if (tap_en != '0) begin
            gap_cnt <= '0;
            if (target != tap_en) tap_en <= '0;
        end else begin
            if (gap_cnt != GAP_LAST) gap_cnt <= gap_cnt + 1'b1;
            if (target != '0 && gap_cnt == GAP_LAST) tap_en <= target;
        end
    end

    // independent run-length counter of all-open cycles
    logic [GW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)                   off_run <= '0;
        else if (tap_en != '0)     off_run <= '0;
        else if (off_run != GAP_FULL) off_run <= off_run + 1'b1;
    end

    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tap_en));

    a_r7_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
        (tap_en != '0) |=> (tap_en == '0 || $stable(tap_en)));

    a_r7_gap_len: assert property (@(posedge clk) disable iff (rst)
        $rose(|tap_en) |-> ($past(off_run) >= GAP_LAST));

endmodule

// File: rtl/chg_hbridge.sv
module chg_hbridge
    import chg_pkg::*;
#(
    parameter int HALF_CYC = 1000000,
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] gate
);

    localparam int            CW    = $clog2(HALF_CYC);
    localparam logic [CW-1:0] LAST  = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] DEADV = CW'(DEAD_CYC);

    logic [CW-1:0] cnt;
    half_e         ph;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            ph  <= PH_POS;
        end else if (cnt == LAST) begin
            cnt <= '0;
            ph  <= (ph == PH_POS) ? PH_NEG : PH_POS;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        gate = (en && cnt >= DEADV) ? gate_pattern(ph) : 4'b0000;
    end

    a_r9_dead_between: assert property (@(posedge clk) disable iff (rst)
        (gate != 4'b0000) |=> (gate == 4'b0000 || $stable(gate)));

    a_r8_legs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate[0] && gate[1]) && !(gate[2] && gate[3]));

endmodule

// File: rtl/pv_charge_tap_ctrl.sv
module pv_charge_tap_ctrl
    import chg_pkg::*;
#(
    parameter int NUM_TAPS     = 4,
    parameter int BATT_FS_CV   = 1200,
    parameter int PV_FS_CV     = 2400,
    parameter int BAND_LO_CV   = 1000,
    parameter int BAND_STEP_CV = 200,
    parameter int GAP_CYC      = 8,
    parameter int CLK_HZ       = 100000000,
    parameter int AC_HZ        = 50,
    parameter int DEAD_CYC     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adc_valid,
    input  logic [7:0]          batt_code,
    input  logic [7:0]          pv_code,
    input  logic [7:0]          thr_low,
    input  logic [7:0]          thr_high,
    output logic [NUM_TAPS-1:0] tap_en,
    output logic [3:0]          gate,
    output logic                charging,
    output logic [CV_W-1:0]     batt_cv
);

    localparam int HALF_CYC = CLK_HZ / (2 * AC_HZ);
    localparam int IDX_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

    chg_state_t          st;
    logic [IDX_W-1:0]    band;
    logic [NUM_TAPS-1:0] target;

    chg_sample #(
        .NUM_TAPS    (NUM_TAPS),
        .BATT_FS_CV  (BATT_FS_CV),
        .PV_FS_CV    (PV_FS_CV),
        .BAND_LO_CV  (BAND_LO_CV),
        .BAND_STEP_CV(BAND_STEP_CV)
    ) i_sample (
        .clk      (clk),
        .rst      (rst),
        .adc_valid(adc_valid),
        .batt_code(batt_code),
        .pv_code  (pv_code),
        .thr_low  (thr_low),
        .thr_high (thr_high),
        .st_q     (st),
        .band_q   (band)
    );

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_target
        assign target[i] = st.charging && st.in_range && (band == IDX_W'(i));
    end

    chg_tap_seq #(
        .NUM_TAPS(NUM_TAPS),
        .GAP_CYC (GAP_CYC)
    ) i_tap_seq (
        .clk   (clk),
        .rst   (rst),
        .target(target),
        .tap_en(tap_en)
    );

    chg_hbridge #(
        .HALF_CYC(HALF_CYC),
        .DEAD_CYC(DEAD_CYC)
    ) i_hbridge (
        .clk (clk),
        .rst (rst),
        .en  (tap_en != '0),
        .gate(gate)
    );

    assign charging = st.charging;
    assign batt_cv  = st.batt_cv;

    a_r6_off_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!charging && $past(!charging)) |-> (tap_en == '0));

    a_r9_bridge_needs_relay: assert property (@(posedge clk) disable iff (rst)
        (tap_en == '0) |-> (gate == 4'b0000));

endmodule

// File: tb/test_pv_charge_tap_ctrl.sv
module test_pv_charge_tap_ctrl;

    localparam int NT    = 4;
    localparam int GAP   = 5;
    localparam int CLKHZ = 100000;
    localparam int ACHZ  = 50;
    localparam int HALF  = CLKHZ / (2 * ACHZ);
    localparam int DEAD  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adc_valid = 1'b0;
    logic [7:0]    batt_code = '0;
    logic [7:0]    pv_code = '0;
    logic [7:0]    thr_low = '0;
    logic [7:0]    thr_high = '0;
    logic [NT-1:0] tap_en;
    logic [3:0]    gate;
    logic          charging;
    logic [11:0]   batt_cv;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  exp_chg = 1'b0;
    int  exp_tap = 0;

    always #5 clk = ~clk;

    pv_charge_tap_ctrl #(
        .NUM_TAPS(NT),
        .GAP_CYC (GAP),
        .CLK_HZ  (CLKHZ),
        .AC_HZ   (ACHZ),
        .DEAD_CYC(DEAD)
    ) i_pv_charge_tap_ctrl (
        .clk      (clk),
        .rst      (rst),
        .adc_valid(adc_valid),
        .batt_code(batt_code),
        .pv_code  (pv_code),
        .thr_low  (thr_low),
        .thr_high (thr_high),
        .tap_en   (tap_en),
        .gate     (gate),
        .charging (charging),
        .batt_cv  (batt_cv)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int scale(input int code, input int fs);
        return code * fs / 255;
    endfunction

    function automatic int tap_for(input int pv, input bit chg);
        int cv;
        cv = scale(pv, 2400);
        if (!chg || cv < 1000 || cv >= 1800) return 0;
        return 1 << ((cv - 1000) / 200);
    endfunction

    function automatic bit next_chg(input bit c, input int b, input int lo, input int hi);
        if (hi <= lo)          return 1'b0;
        if (!c && b < lo)      return 1'b1;
        if (c && b >= hi)      return 1'b0;
        return c;
    endfunction

    function automatic int exp_gate(input int k);
        int c;
        c = k % HALF;
        if (c < DEAD) return 0;
        return ((k / HALF) % 2 == 0) ? 4'b1001 : 4'b0110;
    endfunction

    // drive one sample; returns at the falling edge right after the capture edge
    task automatic apply(input int b, input int p);
        @(negedge clk);
        batt_code = 8'(b);
        pv_code   = 8'(p);
        adc_valid = 1'b1;
        exp_chg   = next_chg(exp_chg, b, int'(thr_low), int'(thr_high));
        exp_tap   = tap_for(p, exp_chg);
        @(negedge clk);
        adc_valid = 1'b0;
        chk("R1 batt_cv", int'(batt_cv), scale(b, 1200));
    endtask

    task automatic settle(input string rq);
        repeat (GAP + 3) @(negedge clk);
        chk(rq, int'(tap_en), exp_tap);
        if (exp_tap == 0) chk("R9 gates off with relays open", int'(gate), 0);
    endtask

    initial begin
        #(1000000 * 1ns);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        int z;
        int bad_k;
        int bad_v;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 tap_en", int'(tap_en), 0);
        chk("R10 gate", int'(gate), 0);
        chk("R10 charging", int'(charging), 0);
        chk("R10 batt_cv", int'(batt_cv), 0);
        rst = 1'b0;
        thr_low  = 8'd180;
        thr_high = 8'd220;

        // R3: between thresholds while idle keeps idle
        apply(200, 117);
        chk("R3 idle between", int'(charging), 0);
        settle("R6 no relay when idle");

        // R2: equal to lower threshold does not start
        apply(180, 117);
        chk("R2 equal low no start", int'(charging), 0);

        // R2: below lower threshold starts; R5 band 0
        apply(179, 117);
        chk("R2 start", int'(charging), 1);
        w = 0;
        while (tap_en == '0 && w < 40) begin @(negedge clk); w++; end
        chk("R5 band0 tap", int'(tap_en), exp_tap);

        // R8 / R9: gate pattern over two periods from relay closure
        bad_k = -1; bad_v = 0;
        for (int k = 0; k < 2 * HALF + 3; k++) begin
            if (bad_k < 0 && int'(gate) != exp_gate(k)) begin bad_k = k; bad_v = int'(gate); end
            @(negedge clk);
        end
        if (bad_k >= 0) chk("R8 R9 gate sequence", bad_v, exp_gate(bad_k));
        else chk("R8 R9 gate sequence", 0, 0);

        // R3: between thresholds while charging keeps charging
        apply(200, 117);
        chk("R3 charge between", int'(charging), 1);

        // R7: tap swap band0 -> band2 with open gap
        apply(200, 160);
        chk("R7 old tap still closed", int'(tap_en), 1);
        @(negedge clk);
        z = 0;
        while (tap_en == '0 && z < 50) begin
            if (gate != 4'b0000) chk("R9 gates during gap", int'(gate), 0);
            z++;
            @(negedge clk);
        end
        chk("R7 gap length", z, GAP);
        chk("R7 new tap", int'(tap_en), 4);

        // R3: reaching upper threshold stops
        apply(220, 160);
        chk("R3 stop at high", int'(charging), 0);
        settle("R6 relays open after stop");

        // R5: out of range and top band boundary
        apply(100, 50);
        chk("R2 restart", int'(charging), 1);
        settle("R5 below span no tap");
        apply(100, 191);
        settle("R5 top band");
        chk("R5 top band is bit3", int'(tap_en), 8);
        apply(100, 192);
        settle("R5 above span no tap");
        apply(100, 255);
        settle("R5 full scale no tap");

        // R1: full scale display, also stops charging
        apply(255, 117);
        chk("R1 full scale 1200", int'(batt_cv), 1200);
        chk("R3 stop full", int'(charging), 0);

        // R4: invalid thresholds
        thr_low = 8'd200; thr_high = 8'd200;
        apply(10, 117);
        chk("R4 bad cfg no start", int'(charging), 0);
        thr_low = 8'd180; thr_high = 8'd220;
        apply(10, 117);
        chk("R4 valid cfg start", int'(charging), 1);
        thr_low = 8'd150; thr_high = 8'd100;
        apply(120, 117);
        chk("R4 bad cfg clears", int'(charging), 0);
        settle("R6 relays open after bad cfg");

        // random mix
        for (int i = 0; i < 60; i++) begin
            int lo;
            int b;
            int p;
            lo = 20 + int'($urandom % 180);
            thr_low  = 8'(lo);
            thr_high = 8'(lo + 1 + int'($urandom % 50));
            b = int'($urandom % 256);
            p = int'($urandom % 256);
            apply(b, p);
            chk("R2 R3 random charging", int'(charging), int'(exp_chg));
            settle("R5 R6 random tap");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule